// File: doc/BRIEF.md
# Reservation Station Pool with Broadcast Wakeup

This block is a small pool of reservation stations that sits in front of one functional-unit class of an out-of-order core. An upstream issue stage hands it one operation per cycle: an opcode and, for each of the two sources, either a finished value (tag zero) or the tag of the station that will produce it. The pool takes the operation into a free station, or refuses it when every station is occupied. It listens to the shared result bus. Whenever a tag it is waiting for goes by, it copies the data into the waiting slot.

A station whose two source tags are both zero is ready. Each cycle, the oldest ready station is sent into a pipelined execution unit with a fixed latency. The unit is modelled as simple 64-bit integer operations. When a result leaves the last pipeline stage, the unit asks for the result bus and keeps the result steady until a grant arrives. The station that produced the result is released when its own tag appears on the bus. An external arbiter drives the granted result onto the bus in the same cycle as the grant.

Top module: `rsp_pool`

## Requirements
- R1: After synchronous reset every station is free, so `iss_ready` is 1 and `bus_req` is 0.
- R2: An issue is taken only when `iss_valid` and `iss_ready` are both 1. `iss_ready` is 0 when every station is busy, and an issue offered then is dropped and produces no result.
- R3: A source tag of 0 means the value supplied with it is final. A source with a nonzero tag holds its station back until that tag is broadcast, and broadcasts of other tags have no effect on it.
- R4: When a tag is broadcast, every station waiting on that tag, in either source slot, captures the bus data in the same cycle.
- R5: If the tag named by an incoming issue is broadcast in the cycle of that issue, the station takes the bus data at once and does not wait.
- R6: A station is sent to execution only when both of its source tags are 0. At most one station is sent per cycle, and among ready stations the one issued earliest goes first.
- R7: Opcode encoding: 0 adds, 1 subtracts (first minus second), 2 multiplies and keeps the low 64 bits, 3 takes the bitwise XOR.
- R8: For an issue whose operands are already final, with the unit idle and the grant available, `bus_req` rises LAT clock edges after the edge that accepts the issue.
- R9: While `bus_req` is 1 and `bus_gnt` is 0, `bus_req`, `bus_req_tag` and `bus_req_data` stay unchanged.
- R10: A station stays busy through execution and becomes free on the edge where its own tag is granted onto the bus.
- R11: Station i carries tag TAG_BASE+i, and `iss_alloc_tag` reports the tag of the lowest-numbered free station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | 2 | Opcode (R7 encoding) |
| iss_src_a_tag | input | 4 | Producer tag of first source, 0 when value is final |
| iss_src_a_val | input | 64 | Value of first source |
| iss_src_b_tag | input | 4 | Producer tag of second source, 0 when value is final |
| iss_src_b_val | input | 64 | Value of second source |
| iss_ready | output | 1 | A station is free to take the issue |
| iss_alloc_tag | output | 4 | Tag the offered issue will receive |
| bus_valid | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | 4 | Producer tag on the result bus |
| bus_data | input | 64 | Data on the result bus |
| bus_req | output | 1 | Execution unit holds a result for the bus |
| bus_gnt | input | 1 | Arbiter grants the bus to this pool |
| bus_req_tag | output | 4 | Tag of the held result |
| bus_req_data | output | 64 | Value of the held result |

## Verification
The bench builds the pool with three stations, tags 1 to 3 and a latency of two. Three stations is the smallest pool in which a younger entry can sit at a lower index than two older ones. This makes oldest-first selection distinguishable from index priority, and it makes a full pool easy to reach for the refusal and release checks. With a two-stage unit, a result can be held back by a withheld grant while a second result waits behind it. Broadcasts from outside the pool use tags 7 to 12, so wakeup, bypass and ignored-tag cases never collide with the pool's own tags.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int RS_DATA_W = 64;
    localparam int RS_TAG_W  = 4;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_XOR = 2'd3
    } rs_op_e;

    typedef struct packed {
        logic                 busy;
        logic                 started;
        rs_op_e               op;
        logic [RS_TAG_W-1:0]  qj;
        logic [RS_TAG_W-1:0]  qk;
        logic [RS_DATA_W-1:0] vj;
        logic [RS_DATA_W-1:0] vk;
    } rs_entry_t;

    typedef struct packed {
        logic                 valid;
        logic [RS_TAG_W-1:0]  tag;
        logic [RS_DATA_W-1:0] data;
    } rs_res_t;

    function automatic logic [RS_DATA_W-1:0] rs_alu(
        input rs_op_e               op,
        input logic [RS_DATA_W-1:0] a,
        input logic [RS_DATA_W-1:0] b
    );
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return a * b;
            default: return a ^ b;
        endcase
    endfunction

endpackage

// File: rtl/rsp_station.sv
module rsp_station
    import rsp_pkg::*;
#(
    parameter int MY_TAG = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc,
    input  rs_op_e               iss_op,
    input  logic [RS_TAG_W-1:0]  iss_qj,
    input  logic [RS_DATA_W-1:0] iss_vj,
    input  logic [RS_TAG_W-1:0]  iss_qk,
    input  logic [RS_DATA_W-1:0] iss_vk,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 ready,
    output rs_entry_t            ent
);

    localparam logic [RS_TAG_W-1:0] OWN_TAG = RS_TAG_W'(MY_TAG);

    rs_entry_t cur;

    // A source snoops the bus only while its tag is nonzero.
    function automatic logic hit(input logic [RS_TAG_W-1:0] q,
                                 input logic v, input logic [RS_TAG_W-1:0] t);
        return (q != '0) && v && (t == q);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (alloc) begin
            cur.busy    <= 1'b1;
            cur.started <= 1'b0;
            cur.op      <= iss_op;
            if (hit(iss_qj, bus_valid, bus_tag)) begin
                cur.qj <= '0;
                cur.vj <= bus_data;
            end else begin
                cur.qj <= iss_qj;
                cur.vj <= iss_vj;
            end
            if (hit(iss_qk, bus_valid, bus_tag)) begin
                cur.qk <= '0;
                cur.vk <= bus_data;
            end else begin
                cur.qk <= iss_qk;
                cur.vk <= iss_vk;
            end
        end else if (cur.busy) begin
            if (start) begin
                cur.started <= 1'b1;
            end
            if (cur.started && bus_valid && (bus_tag == OWN_TAG)) begin
                cur.busy    <= 1'b0;
                cur.started <= 1'b0;
            end
            if (hit(cur.qj, bus_valid, bus_tag)) begin
                cur.qj <= '0;
                cur.vj <= bus_data;
            end
            if (hit(cur.qk, bus_valid, bus_tag)) begin
                cur.qk <= '0;
                cur.vk <= bus_data;
            end
        end
    end

    assign busy  = cur.busy;
    assign ready = cur.busy && !cur.started && (cur.qj == '0) && (cur.qk == '0);
    assign ent   = cur;

endmodule

// File: rtl/rsp_alloc.sv
module rsp_alloc #(
    parameter int NUM_RS = 3,
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
    input  logic              iss_valid,
    input  logic [NUM_RS-1:0] busy_vec,
    output logic              free_any,
    output logic [NUM_RS-1:0] alloc_vec,
    output logic [IDX_W-1:0]  alloc_idx
);

    always_comb begin
        free_any  = 1'b0;
        alloc_vec = '0;
        alloc_idx = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (!free_any && !busy_vec[i]) begin
                free_any     = 1'b1;
                alloc_vec[i] = iss_valid;
                alloc_idx    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rsp_age.sv
module rsp_age #(
    parameter int NUM_RS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_RS-1:0] alloc_vec,
    input  logic [NUM_RS-1:0] ready_vec,
    output logic [NUM_RS-1:0] pick_vec
);

    // older[i][j] set: station i was issued before station j.
    logic [NUM_RS-1:0][NUM_RS-1:0] older;

    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int i = 0; i < NUM_RS; i++) begin
                for (int j = 0; j < NUM_RS; j++) begin
                    if (alloc_vec[i]) begin
                        older[i][j] <= 1'b0;
                    end else if (alloc_vec[j] && (i != j)) begin
                        older[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_RS; g++) begin : g_pick
            logic blocked;
            always_comb begin
                blocked = 1'b0;
                for (int j = 0; j < NUM_RS; j++) begin
                    if (ready_vec[j] && older[j][g]) begin
                        blocked = 1'b1;
                    end
                end
            end
            assign pick_vec[g] = ready_vec[g] && !blocked;
        end
    endgenerate

endmodule

// File: rtl/rsp_exec_pipe.sv
module rsp_exec_pipe
    import rsp_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [RS_TAG_W-1:0]  in_tag,
    input  rs_op_e               in_op,
    input  logic [RS_DATA_W-1:0] in_a,
    input  logic [RS_DATA_W-1:0] in_b,
    output logic                 in_ready,
    input  logic                 gnt,
    output rs_res_t              out
);

    rs_res_t st [LAT];
    logic    advance;

    // The whole pipe freezes while the head waits for a grant.
    assign advance  = !st[LAT-1].valid || gnt;
    assign in_ready = advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++) begin
                st[k] <= '0;
            end
        end else if (advance) begin
            st[0] <= '{valid: in_valid, tag: in_tag, data: rs_alu(in_op, in_a, in_b)};
            for (int k = 1; k < LAT; k++) begin
                st[k] <= st[k-1];
            end
        end
    end

    assign out = st[LAT-1];

endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
    import rsp_pkg::*;
#(
    parameter int NUM_RS   = 3,
    parameter int TAG_BASE = 1,
    parameter int LAT      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [1:0]           iss_op,
    input  logic [RS_TAG_W-1:0]  iss_src_a_tag,
    input  logic [RS_DATA_W-1:0] iss_src_a_val,
    input  logic [RS_TAG_W-1:0]  iss_src_b_tag,
    input  logic [RS_DATA_W-1:0] iss_src_b_val,
    output logic                 iss_ready,
    output logic [RS_TAG_W-1:0]  iss_alloc_tag,
    input  logic                 bus_valid,
    input  logic [RS_TAG_W-1:0]  bus_tag,
    input  logic [RS_DATA_W-1:0] bus_data,
    output logic                 bus_req,
    input  logic                 bus_gnt,
    output logic [RS_TAG_W-1:0]  bus_req_tag,
    output logic [RS_DATA_W-1:0] bus_req_data
);

    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    logic [NUM_RS-1:0] busy_vec;
    logic [NUM_RS-1:0] ready_vec;
    logic [NUM_RS-1:0] alloc_vec;
    logic [NUM_RS-1:0] pick_vec;
    logic [NUM_RS-1:0] start_vec;
    logic [IDX_W-1:0]  alloc_idx;
    logic              free_any;
    rs_entry_t         ents [NUM_RS];

    logic                 pipe_ready;
    logic                 disp_valid;
    logic [RS_TAG_W-1:0]  disp_tag;
    rs_op_e               disp_op;
    logic [RS_DATA_W-1:0] disp_a;
    logic [RS_DATA_W-1:0] disp_b;
    rs_res_t              head;

    rsp_alloc #(.NUM_RS(NUM_RS)) u_alloc (
        .iss_valid (iss_valid),
        .busy_vec  (busy_vec),
        .free_any  (free_any),
        .alloc_vec (alloc_vec),
        .alloc_idx (alloc_idx)
    );

    assign iss_ready     = free_any;
    assign iss_alloc_tag = RS_TAG_W'(TAG_BASE) + RS_TAG_W'(alloc_idx);

    generate
        for (genvar g = 0; g < NUM_RS; g++) begin : g_st
            rsp_station #(.MY_TAG(TAG_BASE + g)) u_st (
                .clk       (clk),
                .rst       (rst),
                .alloc     (alloc_vec[g]),
                .iss_op    (rs_op_e'(iss_op)),
                .iss_qj    (iss_src_a_tag),
                .iss_vj    (iss_src_a_val),
                .iss_qk    (iss_src_b_tag),
                .iss_vk    (iss_src_b_val),
                .bus_valid (bus_valid),
                .bus_tag   (bus_tag),
                .bus_data  (bus_data),
                .start     (start_vec[g]),
                .busy      (busy_vec[g]),
                .ready     (ready_vec[g]),
                .ent       (ents[g])
            );
        end
    endgenerate

    rsp_age #(.NUM_RS(NUM_RS)) u_age (
        .clk       (clk),
        .rst       (rst),
        .alloc_vec (alloc_vec),
        .ready_vec (ready_vec),
        .pick_vec  (pick_vec)
    );

    assign start_vec = pick_vec & {NUM_RS{pipe_ready}};

    always_comb begin
        disp_valid = 1'b0;
        disp_tag   = '0;
        disp_op    = OP_ADD;
        disp_a     = '0;
        disp_b     = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (pick_vec[i]) begin
                disp_valid = 1'b1;
                disp_tag   = RS_TAG_W'(TAG_BASE + i);
                disp_op    = ents[i].op;
                disp_a     = ents[i].vj;
                disp_b     = ents[i].vk;
            end
        end
    end

    rsp_exec_pipe #(.LAT(LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_valid (disp_valid),
        .in_tag   (disp_tag),
        .in_op    (disp_op),
        .in_a     (disp_a),
        .in_b     (disp_b),
        .in_ready (pipe_ready),
        .gnt      (bus_gnt),
        .out      (head)
    );

    assign bus_req      = head.valid;
    assign bus_req_tag  = head.tag;
    assign bus_req_data = head.data;

endmodule

// File: rtl/rsp_pool_chk.sv
module rsp_pool_chk #(
    parameter int NUM_RS   = 3,
    parameter int TAG_BASE = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [NUM_RS-1:0] busy_vec,
    input logic [NUM_RS-1:0] alloc_vec,
    input logic [NUM_RS-1:0] start_vec,
    input logic [NUM_RS-1:0] ready_vec,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [3:0]        bus_req_tag,
    input logic [63:0]       bus_req_data
);

    logic [3:0] gnt_off;
    assign gnt_off = bus_req_tag - 4'(TAG_BASE);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (iss_ready && !bus_req));

    assert_accept_free_R2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |-> (($countones(alloc_vec) == 1) && ((alloc_vec & busy_vec) == '0)));

    assert_one_ready_start_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_vec) && ((start_vec & ~ready_vec) == '0));

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_req_tag) && $stable(bus_req_data)));

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        bus_gnt |=> (((busy_vec >> $past(gnt_off)) & 1) == 0));

    assert_tag_range_R11: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ((int'(bus_req_tag) >= TAG_BASE) && (int'(bus_req_tag) < TAG_BASE + NUM_RS)));

endmodule

bind rsp_pool rsp_pool_chk #(.NUM_RS(NUM_RS), .TAG_BASE(TAG_BASE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .iss_valid    (iss_valid),
    .iss_ready    (iss_ready),
    .busy_vec     (busy_vec),
    .alloc_vec    (alloc_vec),
    .start_vec    (start_vec),
    .ready_vec    (ready_vec),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .bus_req_tag  (bus_req_tag),
    .bus_req_data (bus_req_data)
);

// File: tb/rsp_pool_test.sv
module rsp_pool_test;
    import rsp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NRS  = 3;
    localparam int TB0  = 1;
    localparam int PLAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = 2'd0;
    logic [3:0]  iss_a_tag = '0, iss_b_tag = '0;
    logic [63:0] iss_a_val = '0, iss_b_val = '0;
    logic        iss_ready;
    logic [3:0]  iss_alloc_tag;
    logic        ext_valid = 1'b0;
    logic [3:0]  ext_tag = '0;
    logic [63:0] ext_data = '0;
    logic        gnt_en = 1'b1;
    logic        bus_valid, bus_req, bus_gnt;
    logic [3:0]  bus_tag, bus_req_tag;
    logic [63:0] bus_data, bus_req_data;

    int total = 0;
    int bad = 0;
    int res_n = 0;
    logic [3:0]  res_tag  [64];
    logic [63:0] res_data [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench arbiter: external traffic wins, otherwise the pool is granted.
    assign bus_gnt   = gnt_en && bus_req && !ext_valid;
    assign bus_valid = ext_valid || bus_gnt;
    assign bus_tag   = ext_valid ? ext_tag  : bus_req_tag;
    assign bus_data  = ext_valid ? ext_data : bus_req_data;

    rsp_pool #(.NUM_RS(NRS), .TAG_BASE(TB0), .LAT(PLAT)) uut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a_tag(iss_a_tag), .iss_src_a_val(iss_a_val),
        .iss_src_b_tag(iss_b_tag), .iss_src_b_val(iss_b_val),
        .iss_ready(iss_ready), .iss_alloc_tag(iss_alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_req_tag(bus_req_tag), .bus_req_data(bus_req_data)
    );

    always @(posedge clk) begin
        if (bus_gnt && res_n < 64) begin
            res_tag[res_n]  <= bus_req_tag;
            res_data[res_n] <= bus_req_data;
            res_n <= res_n + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input rs_op_e op, input logic [3:0] qa, input logic [63:0] va,
                         input logic [3:0] qb, input logic [63:0] vb);
        @(negedge clk);
        iss_valid = 1'b1; iss_op = op;
        iss_a_tag = qa; iss_a_val = va; iss_b_tag = qb; iss_b_val = vb;
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [63:0] d);
        @(negedge clk);
        ext_valid = 1'b1; ext_tag = t; ext_data = d;
        @(negedge clk);
        ext_valid = 1'b0;
    endtask

    task automatic wait_res(input int n, input string req);
        int k;
        k = 0;
        while (res_n < n && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(req, 64'(res_n), 64'(n));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 iss_ready after reset", 64'(iss_ready), 64'd1);
        chk("R1 bus_req after reset", 64'(bus_req), 64'd0);
        chk("R11 first alloc tag", 64'(iss_alloc_tag), 64'(TB0));
    endtask

    task automatic t_latency;
        res_n = 0;
        @(negedge clk);
        iss_valid = 1'b1; iss_op = OP_ADD;
        iss_a_tag = 0; iss_a_val = 64'd3; iss_b_tag = 0; iss_b_val = 64'd4;
        @(negedge clk);
        iss_valid = 1'b0;
        chk("R8 no request one edge after issue", 64'(bus_req), 64'd0);
        for (int e = 1; e < PLAT; e++) begin
            @(negedge clk);
            chk("R8 no request before latency", 64'(bus_req), 64'd0);
        end
        @(negedge clk);
        chk("R8 request at latency", 64'(bus_req), 64'd1);
        wait_res(1, "R8 result count");
        chk("R7 add result", res_data[0], 64'd7);
        chk("R11 tag of station 0", 64'(res_tag[0]), 64'(TB0));
    endtask

    task automatic t_ops;
        logic [63:0] a, b;
        res_n = 0;
        a = 64'h0000_0001_0000_0000;
        b = 64'h0000_0001_0000_0005;
        issue(OP_SUB, 0, 64'd5, 0, 64'd9);
        issue(OP_MUL, 0, a, 0, b);
        issue(OP_XOR, 0, 64'hF0F0_0000_1234_5678, 0, 64'hFFFF_0000_0000_00FF);
        issue(OP_ADD, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd2);
        wait_res(4, "R7 op results count");
        chk("R7 sub", res_data[0], 64'd5 - 64'd9);
        chk("R7 mul low bits", res_data[1], a * b);
        chk("R7 xor", res_data[2], 64'hF0F0_0000_1234_5678 ^ 64'hFFFF_0000_0000_00FF);
        chk("R7 add wraps", res_data[3], 64'd1);
    endtask

    task automatic t_wakeup;
        res_n = 0;
        issue(OP_ADD, 4'd7, 64'hDEAD, 0, 64'd10);
        issue(OP_SUB, 0, 64'd100, 4'd7, 64'hBEEF);
        bcast(4'd8, 64'd999);
        repeat (5) @(negedge clk);
        chk("R3 waiting stations ignore other tag", 64'(res_n), 64'd0);
        chk("R3 no request while waiting", 64'(bus_req), 64'd0);
        bcast(4'd7, 64'd50);
        wait_res(2, "R4 both waiters woke");
        chk("R4 first slot captured", res_data[0], 64'd60);
        chk("R4 second slot captured", res_data[1], 64'd50);
        chk("R11 second station tag", 64'(res_tag[1]), 64'(TB0 + 1));
    endtask

    task automatic t_age_full;
        res_n = 0;
        issue(OP_ADD, 4'd9,  64'd0, 0, 64'd1);
        issue(OP_ADD, 4'd10, 64'd0, 0, 64'd2);
        issue(OP_ADD, 4'd10, 64'd0, 0, 64'd3);
        chk("R2 ready low when full", 64'(iss_ready), 64'd0);
        issue(OP_ADD, 0, 64'd40, 0, 64'd40);
        bcast(4'd9, 64'd100);
        wait_res(1, "R6 first waiter ran");
        chk("R6 first result", res_data[0], 64'd101);
        chk("R10 station freed by own broadcast", 64'(iss_ready), 64'd1);
        chk("R11 freed station offered", 64'(iss_alloc_tag), 64'(TB0));
        issue(OP_ADD, 4'd10, 64'd0, 0, 64'd4);
        bcast(4'd10, 64'd200);
        wait_res(4, "R2 refused issue gave no result");
        repeat (4) @(negedge clk);
        chk("R2 no extra result", 64'(res_n), 64'd4);
        chk("R6 oldest first tag", 64'(res_tag[1]), 64'(TB0 + 1));
        chk("R6 second oldest tag", 64'(res_tag[2]), 64'(TB0 + 2));
        chk("R6 youngest last tag", 64'(res_tag[3]), 64'(TB0));
        chk("R6 youngest last data", res_data[3], 64'd204);
    endtask

    task automatic t_bypass;
        res_n = 0;
        @(negedge clk);
        iss_valid = 1'b1; iss_op = OP_ADD;
        iss_a_tag = 4'd12; iss_a_val = 64'd0; iss_b_tag = 0; iss_b_val = 64'd5;
        ext_valid = 1'b1; ext_tag = 4'd12; ext_data = 64'd70;
        @(negedge clk);
        iss_valid = 1'b0; ext_valid = 1'b0;
        wait_res(1, "R5 same-cycle wakeup not lost");
        chk("R5 bypassed value", res_data[0], 64'd75);
    endtask

    task automatic t_hold;
        logic [3:0]  ht;
        logic [63:0] hd;
        res_n = 0;
        gnt_en = 1'b0;
        issue(OP_XOR, 0, 64'h11, 0, 64'h01);
        issue(OP_XOR, 0, 64'h22, 0, 64'h02);
        issue(OP_XOR, 0, 64'h33, 0, 64'h03);
        repeat (4) @(negedge clk);
        chk("R9 request pending", 64'(bus_req), 64'd1);
        chk("R10 busy until broadcast", 64'(iss_ready), 64'd0);
        ht = bus_req_tag; hd = bus_req_data;
        repeat (3) @(negedge clk);
        chk("R9 tag held", 64'(bus_req_tag), 64'(ht));
        chk("R9 data held", bus_req_data, hd);
        chk("R9 oldest data at head", hd, 64'h10);
        gnt_en = 1'b1;
        @(negedge clk);
        gnt_en = 1'b0;
        chk("R10 one station freed after grant", 64'(iss_ready), 64'd1);
        chk("R9 single grant", 64'(res_n), 64'd1);
        gnt_en = 1'b1;
        wait_res(3, "R9 remaining results");
        chk("R9 second result", res_data[1], 64'h20);
        chk("R9 third result", res_data[2], 64'h30);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latency();
        t_ops();
        t_wakeup();
        t_age_full();
        t_bypass();
        t_hold();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule